// File: doc/BRIEF.md
# Inband Loopback Code Detector

This block watches a received T1 payload bit stream for two repeating in-band loopback codes, one that requests a loopback and one that releases it. Each bit arrives with a one-cycle strobe and a flag that marks the frame bit. Two identical channels run side by side, one per code. Each channel has an 8-bit code word and a 2-bit length select, and hunts for the repeating pattern in the stream.

A channel locks once it has seen four unbroken repetitions of its code. It then counts bit errors over fixed measurement periods. It declares the code present after a long run of clean periods. It drops detection, and hunts again, as soon as one period collects too many errors.

In framed mode the frame bit is either skipped or compared. When it is compared, its result is thrown away. Any change of a channel's status in either direction raises a sticky flag for that channel. The interrupt line is the OR of the flags whose enable bit is set.

Top module: `inband_loop_detect`

## Requirements
- R1: After reset, both status bits, both flags and the interrupt line are 0.
- R2: Length select 00, 01, 10 and 11 gives a code of 5, 6, 7 and 8 bits. The code is the top bits of the 8-bit code word, and bit 7 of the word is the first bit expected on the line.
- R3: Lock needs the last L compared bits to equal the code, followed by 3·L further bits that match the running code position, which makes four repetitions. A mismatch before lock sends the channel back to hunting.
- R4: Counting starts at the strobe after lock, and each measurement period is PERIOD_BITS strobes. Status sets on the strobe that closes the (GOOD_PERIODS+1)-th consecutive period with fewer than ERR_LIM errors. status_o only changes on an edge where bit_vld_i is 1.
- R5: A period that ends with exactly ERR_LIM errors restarts the run of good periods. It does not clear the status.
- R6: On the strobe where a period's error count exceeds ERR_LIM, status clears and the channel hunts again. Periods with fewer errors leave the status set.
- R7: When framed_i=1 and fbit_cmp_i=1, a frame bit takes up a code position, but its value never counts as an error and never breaks lock acquisition.
- R8: When framed_i=1 and fbit_cmp_i=0, frame bits are not compared and do not advance the code position. They still count as bit times in the period.
- R9: When framed_i=0, fbit_i is ignored and every strobed bit is compared.
- R10: Channel 0 (activate code, status_o[0]) and channel 1 (deactivate code, status_o[1]) work independently.
- R11: A change of status_o[n] sets irq_flag_o[n] on the next edge. The flag holds until irq_clr_i[n]=1, and a set on the same edge wins over the clear.
- R12: irq_o is 1 exactly when some n has irq_flag_o[n]=1 and irq_en_i[n]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe marking a received bit |
| bit_i | input | 1 | Received bit value |
| fbit_i | input | 1 | The strobed bit is the frame bit |
| framed_i | input | 1 | 1 = framed stream, 0 = unframed |
| fbit_cmp_i | input | 1 | In framed mode, the frame bit takes part in the comparison |
| act_code_i | input | 8 | Activate code word |
| act_len_i | input | 2 | Activate code length select |
| deact_code_i | input | 8 | Deactivate code word |
| deact_len_i | input | 2 | Deactivate code length select |
| irq_en_i | input | 2 | Per-channel interrupt enable |
| irq_clr_i | input | 2 | Per-channel flag clear |
| status_o | output | 2 | Detection status: [0] activate, [1] deactivate |
| irq_flag_o | output | 2 | Sticky transition flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench predicts the exact strobe on which status rises for every code length. A design with a wrong lock count or a wrong period alignment rises early or late, and the bench checks both the strobe before and the strobe itself. It places exactly ERR_LIM errors in one period, which exposes a design that treats the limit as clean, and it times the drop to the strobe of the first error over the limit. Frame bits that are wrong on every eighth strobe catch a design that counts them as errors or lets them break the hunt. Skipped frame bits with random values catch a design that advances the code position on them. An error during lock acquisition must push the rise back by a computed amount.

// File: rtl/inband_lb_pkg.sv
package inband_lb_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_MON    = 2'd2
  } lock_st_e;

  function automatic logic [3:0] code_len(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/lb_classify.sv
module lb_classify (
  input  logic bit_vld_i,
  input  logic fbit_i,
  input  logic framed_i,
  input  logic fbit_cmp_i,
  output logic cmp_o,
  output logic wild_o
);
  logic is_fbit;
  assign is_fbit = framed_i & fbit_i;
  // compared: everything except a framed frame bit that is excluded
  assign cmp_o  = bit_vld_i & (~is_fbit | fbit_cmp_i);
  // compared frame bit: takes a code slot, result discarded
  assign wild_o = is_fbit & fbit_cmp_i;
endmodule

// File: rtl/lb_aligner.sv
module lb_aligner
  import inband_lb_pkg::*;
#(
  parameter int LOCK_REPS = 4,
  localparam int RW = (LOCK_REPS > 2) ? $clog2(LOCK_REPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  input  logic              wild_i,
  input  logic              bit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        len_sel_i,
  input  logic              drop_i,
  output logic              lock_o,
  output logic              mon_o,
  output logic              miss_o
);
  lock_st_e          st_q;
  logic [CODE_W-1:0] win_q, msk_q, win_n, msk_n;
  logic [3:0]        fill_q, fill_n, len;
  logic [2:0]        ptr_q, ptr_nxt;
  logic [RW-1:0]     reps_q;
  logic              exp_bit, bad_bit, wrap, last_rep, win_hit, fill_ok;

  assign len     = code_len(len_sel_i);
  assign win_n   = {win_q[CODE_W-2:0], bit_i};
  assign msk_n   = {msk_q[CODE_W-2:0], wild_i};
  assign fill_n  = (fill_q == 4'(CODE_W)) ? fill_q : fill_q + 4'd1;
  assign fill_ok = fill_n >= len;

  assign exp_bit  = code_i[3'd7 - ptr_q];
  assign bad_bit  = ~wild_i & (bit_i != exp_bit);
  assign wrap     = {1'b0, ptr_q} >= (len - 4'd1);
  assign ptr_nxt  = wrap ? 3'd0 : ptr_q + 3'd1;
  assign last_rep = reps_q == RW'(LOCK_REPS - 1);

  // newest bit sits at window bit 0 and lines up with the last code bit
  always_comb begin
    win_hit = 1'b1;
    for (int j = 0; j < CODE_W; j++) begin
      if ((4'(j) < len) && !msk_n[j] &&
          (win_n[j] != code_i[3'(4'(CODE_W) - len + 4'(j))]))
        win_hit = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      win_q  <= '0;
      msk_q  <= '0;
      fill_q <= '0;
      ptr_q  <= '0;
      reps_q <= '0;
    end else begin
      if (cmp_i) begin
        win_q  <= win_n;
        msk_q  <= msk_n;
        fill_q <= fill_n;
      end
      unique case (st_q)
        ST_HUNT: begin
          if (cmp_i && fill_ok && win_hit) begin
            st_q   <= ST_VERIFY;
            ptr_q  <= '0;
            reps_q <= RW'(1);
          end
        end
        ST_VERIFY: begin
          if (cmp_i) begin
            if (bad_bit) begin
              st_q <= ST_HUNT;
            end else begin
              ptr_q <= ptr_nxt;
              if (wrap) begin
                if (last_rep) st_q <= ST_MON;
                else          reps_q <= reps_q + RW'(1);
              end
            end
          end
        end
        ST_MON: begin
          if (drop_i)     st_q  <= ST_HUNT;
          else if (cmp_i) ptr_q <= ptr_nxt;
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  assign lock_o = (st_q == ST_VERIFY) & cmp_i & ~bad_bit & wrap & last_rep;
  assign mon_o  = (st_q == ST_MON);
  assign miss_o = (st_q == ST_MON) & cmp_i & bad_bit;
endmodule

// File: rtl/lb_qualifier.sv
module lb_qualifier #(
  parameter int PERIOD_BITS  = 61440,
  parameter int ERR_LIM      = 600,
  parameter int GOOD_PERIODS = 126,
  localparam int PW = $clog2(PERIOD_BITS),
  localparam int EW = $clog2(ERR_LIM + 2),
  localparam int GW = $clog2(GOOD_PERIODS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic lock_i,
  input  logic mon_i,
  input  logic miss_i,
  output logic drop_o,
  output logic det_o
);
  logic [PW-1:0] per_q;
  logic [EW-1:0] err_q, err_n;
  logic [GW-1:0] good_q;
  logic          per_end;

  assign err_n   = err_q + EW'(miss_i);
  assign per_end = vld_i & (per_q == PW'(PERIOD_BITS - 1));
  assign drop_o  = mon_i & (err_n > EW'(ERR_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      err_q  <= '0;
      good_q <= '0;
      det_o  <= 1'b0;
    end else if (lock_i) begin
      per_q  <= '0;
      err_q  <= '0;
      good_q <= '0;
    end else if (mon_i) begin
      if (drop_o) begin
        det_o  <= 1'b0;
        good_q <= '0;
        err_q  <= '0;
        per_q  <= '0;
      end else if (vld_i) begin
        if (per_end) begin
          per_q <= '0;
          err_q <= '0;
          if (err_n == EW'(ERR_LIM)) good_q <= '0;
          else if (good_q == GW'(GOOD_PERIODS)) det_o <= 1'b1;
          else good_q <= good_q + GW'(1);
        end else begin
          per_q <= per_q + PW'(1);
          err_q <= err_n;
        end
      end
    end
  end
endmodule

// File: rtl/lb_irq_flag.sv
module lb_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic status_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      prev_q <= status_i;
      if (status_i != prev_q) flag_o <= 1'b1;
      else if (clr_i)         flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/inband_loop_detect.sv
module inband_loop_detect
  import inband_lb_pkg::*;
#(
  parameter int PERIOD_BITS  = 61440,
  parameter int ERR_LIM      = 600,
  parameter int GOOD_PERIODS = 126,
  parameter int LOCK_REPS    = 4,
  localparam int NCH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  input  logic       fbit_i,
  input  logic       framed_i,
  input  logic       fbit_cmp_i,
  input  logic [7:0] act_code_i,
  input  logic [1:0] act_len_i,
  input  logic [7:0] deact_code_i,
  input  logic [1:0] deact_len_i,
  input  logic [1:0] irq_en_i,
  input  logic [1:0] irq_clr_i,
  output logic [1:0] status_o,
  output logic [1:0] irq_flag_o,
  output logic       irq_o
);
  logic              cmp, wild;
  logic [CODE_W-1:0] code [NCH];
  logic [1:0]        lsel [NCH];

  assign code[0] = act_code_i;
  assign code[1] = deact_code_i;
  assign lsel[0] = act_len_i;
  assign lsel[1] = deact_len_i;

  lb_classify i_classify (
    .bit_vld_i (bit_vld_i),
    .fbit_i    (fbit_i),
    .framed_i  (framed_i),
    .fbit_cmp_i(fbit_cmp_i),
    .cmp_o     (cmp),
    .wild_o    (wild)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic lock, mon, miss, drop;

    lb_aligner #(.LOCK_REPS(LOCK_REPS)) i_align (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmp_i    (cmp),
      .wild_i   (wild),
      .bit_i    (bit_i),
      .code_i   (code[ch]),
      .len_sel_i(lsel[ch]),
      .drop_i   (drop),
      .lock_o   (lock),
      .mon_o    (mon),
      .miss_o   (miss)
    );

    lb_qualifier #(
      .PERIOD_BITS (PERIOD_BITS),
      .ERR_LIM     (ERR_LIM),
      .GOOD_PERIODS(GOOD_PERIODS)
    ) i_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (bit_vld_i),
      .lock_i(lock),
      .mon_i (mon),
      .miss_i(miss),
      .drop_o(drop),
      .det_o (status_o[ch])
    );

    lb_irq_flag i_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .status_i(status_o[ch]),
      .clr_i   (irq_clr_i[ch]),
      .flag_o  (irq_flag_o[ch])
    );
  end

  assign irq_o = |(irq_flag_o & irq_en_i);
endmodule

// File: rtl/inband_loop_detect_chk.sv
module inband_loop_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic [1:0] irq_clr_i,
  input logic [1:0] status_o,
  input logic [1:0] irq_flag_o
);
  for (genvar ch = 0; ch < 2; ch++) begin : g_a
    p_status_on_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(bit_vld_i) |-> $stable(status_o[ch]));

    p_flag_on_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[ch] != $past(status_o[ch])) |=> irq_flag_o[ch]);

    p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_flag_o[ch] && !irq_clr_i[ch]) |=> irq_flag_o[ch]);

    p_flag_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_flag_o[ch]) |-> ($past(status_o[ch]) != $past(status_o[ch], 2)));

    p_flag_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_clr_i[ch] && (status_o[ch] == $past(status_o[ch]))) |=> !irq_flag_o[ch]);
  end
endmodule

bind inband_loop_detect inband_loop_detect_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_vld_i (bit_vld_i),
  .irq_clr_i (irq_clr_i),
  .status_o  (status_o),
  .irq_flag_o(irq_flag_o)
);

// File: tb/test_inband_loop_detect.sv
`timescale 1ns/1ps
module test_inband_loop_detect;
  localparam int P  = 64;
  localparam int EL = 4;
  localparam int GP = 3;
  localparam int LR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 0, bit_v = 0, fbit = 0, framed = 0, fcmp = 0;
  logic [7:0] act_code = 0, deact_code = 0;
  logic [1:0] act_len = 0, deact_len = 0, irq_en = 0, irq_clr = 0;
  logic [1:0] status, flag;
  logic       irq;

  int n_chk = 0, n_bad = 0, sidx = 0, pos = 0;
  bit done = 0;
  logic [1023:0] flipm;

  always #2.5 clk = ~clk;

  inband_loop_detect #(.PERIOD_BITS(P), .ERR_LIM(EL), .GOOD_PERIODS(GP), .LOCK_REPS(LR))
  i_inband_loop_detect (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .bit_i(bit_v), .fbit_i(fbit),
    .framed_i(framed), .fbit_cmp_i(fcmp),
    .act_code_i(act_code), .act_len_i(act_len),
    .deact_code_i(deact_code), .deact_len_i(deact_len),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .status_o(status), .irq_flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at strobe %0d: actual=%0d expected=%0d", req, sidx, act, exp);
    end
  endtask

  // strobe after which status rises, given the strobe index of lock
  function automatic int rise_at(input int lk);
    return lk + (GP + 1) * P;
  endfunction

  // strobe index of compared bit j when every 8th strobe is a skipped frame bit
  function automatic int c2s(input int j);
    return j + j / 7;
  endfunction

  task automatic reset_dut();
    vld = 0; irq_clr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sidx = 0; pos = 0; flipm = '0;
  endtask

  task automatic strobe(input logic b, input logic f);
    vld = 1; bit_v = b; fbit = f;
    @(negedge clk);
    vld = 0;
    @(negedge clk);
    sidx++;
  endtask

  task automatic code_bit(input logic [7:0] c, input int len, input logic inv, input logic f);
    logic b;
    b = c[3'(7 - pos)] ^ flipm[sidx] ^ inv;
    pos = (pos + 1) % len;
    strobe(b, f);
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    irq_clr = m;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic place_errs(input int lk, input int k, input int n);
    int base, cnt;
    base = lk + 1 + P * (k - 1);
    cnt = 0;
    while (cnt < n) begin
      int o;
      o = 1 + int'($urandom % (P - 2));
      if (!flipm[base + o]) begin
        flipm[base + o] = 1'b1;
        cnt++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ra, e4, e5, seen, lk;
    void'($urandom(32'd4711));

    // A: unframed, length 5, random frame flag ignored
    framed = 0; fcmp = 0;
    act_code = 8'hB0; act_len = 2'b00;
    deact_code = 8'hE0; deact_len = 2'b01;
    irq_en = 2'b01;
    reset_dut();
    chk("R1 status", int'(status), 0);
    chk("R1 flags", int'(flag), 0);
    chk("R1 irq", int'(irq), 0);
    ra = rise_at(4 * 5 - 1);
    for (int i = 0; i <= ra; i++) begin
      code_bit(act_code, 5, 1'b0, logic'($urandom % 2));
      if (i == ra - 1) chk("R4 R9 no early rise", int'(status[0]), 0);
    end
    chk("R4 R9 rise on exact strobe", int'(status[0]), 1);
    chk("R10 deact idle", int'(status[1]), 0);
    @(negedge clk);
    chk("R11 flag on rise", int'(flag[0]), 1);
    chk("R12 irq enabled", int'(irq), 1);
    pulse_clr(2'b01);
    chk("R11 flag cleared", int'(flag[0]), 0);
    chk("R12 irq after clear", int'(irq), 0);

    // B1: framed, frame bit compared but always wrong
    framed = 1; fcmp = 1;
    reset_dut();
    for (int i = 0; i <= ra; i++) begin
      logic f;
      f = (i % 8 == 7);
      code_bit(act_code, 5, f, f);
      if (i == ra - 1) chk("R7 no early rise", int'(status[0]), 0);
    end
    chk("R7 wrong frame bits discarded", int'(status[0]), 1);

    // B2: framed, frame bits skipped with random values
    framed = 1; fcmp = 0;
    reset_dut();
    ra = rise_at(c2s(4 * 5 - 1));
    for (int i = 0; i <= ra; i++) begin
      if (i % 8 == 7) strobe(logic'($urandom % 2), 1'b1);
      else            code_bit(act_code, 5, 1'b0, 1'b0);
      if (i == ra - 1) chk("R8 no early rise", int'(status[0]), 0);
    end
    chk("R8 skipped frame bits", int'(status[0]), 1);

    // V: error during lock acquisition at bit 10; next aligned window ends at 19, lock at 34
    framed = 0; fcmp = 0;
    reset_dut();
    flipm[10] = 1'b1;
    ra = rise_at(34);
    for (int i = 0; i <= ra; i++) begin
      code_bit(act_code, 5, 1'b0, 1'b0);
      if (i == ra - 1) chk("R3 restart delays rise", int'(status[0]), 0);
    end
    chk("R3 rise after relock", int'(status[0]), 1);

    // C: error counting around the limit
    reset_dut();
    lk = 19;
    place_errs(lk, 2, EL);
    place_errs(lk, 7, EL - 1);
    place_errs(lk, 8, EL + 1);
    seen = 0; e4 = 0; e5 = 0;
    for (int i = lk + 1 + 7 * P; i <= lk + 8 * P; i++) begin
      if (flipm[i]) begin
        seen++;
        if (seen == EL) e4 = i;
        if (seen == EL + 1) e5 = i;
      end
    end
    ra = lk + 6 * P;
    for (int i = 0; i <= e5; i++) begin
      code_bit(act_code, 5, 1'b0, 1'b0);
      if (i == ra - 1) chk("R5 limit period restarts run", int'(status[0]), 0);
      if (i == ra) begin
        chk("R5 rise after fresh run", int'(status[0]), 1);
        @(negedge clk);
        pulse_clr(2'b01);
      end
      if (i == lk + 7 * P) chk("R6 below limit keeps status", int'(status[0]), 1);
      if (i == e4) chk("R6 at limit keeps status", int'(status[0]), 1);
    end
    chk("R6 drop on excess error", int'(status[0]), 0);
    @(negedge clk);
    chk("R11 flag on fall", int'(flag[0]), 1);

    // D: deactivate channel, length 6, interrupt masking
    act_code = 8'hF0; act_len = 2'b11;
    deact_code = 8'hE0; deact_len = 2'b01;
    irq_en = 2'b00;
    reset_dut();
    ra = rise_at(4 * 6 - 1);
    for (int i = 0; i <= ra; i++) begin
      code_bit(deact_code, 6, 1'b0, 1'b0);
      if (i == ra - 1) chk("R10 deact no early rise", int'(status[1]), 0);
    end
    chk("R10 deact rise", int'(status[1]), 1);
    chk("R10 act untouched", int'(status[0]), 0);
    @(negedge clk);
    chk("R11 deact flag", int'(flag[1]), 1);
    chk("R12 masked", int'(irq), 0);
    irq_en = 2'b10; #1;
    chk("R12 enabled ch1", int'(irq), 1);
    irq_en = 2'b01; #1;
    chk("R12 other enable", int'(irq), 0);
    irq_en = 2'b00;

    // E: each length with a random code word
    for (int len = 5; len <= 8; len++) begin
      logic [7:0] c;
      c = 8'($urandom);
      act_code = c; act_len = 2'(len - 5);
      reset_dut();
      ra = rise_at(4 * len - 1);
      for (int i = 0; i <= ra; i++) begin
        code_bit(c, len, 1'b0, 1'b0);
        if (i == ra - 1) chk($sformatf("R2 len %0d no early rise", len), int'(status[0]), 0);
      end
      chk($sformatf("R2 len %0d rise", len), int'(status[0]), 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule